// File: doc/BRIEF.md
# Sealed Image Header Validator

This controller stands between reset and the first instruction fetch of a secure processor. Straight after reset it reads the 32-word secure header at the base of a word-addressed image memory, one word per cycle, through a synchronous read port. It then works through a fixed chain of checks. The field and bounds checks are resolved locally. The two 128-bit authentication tags come from an external MAC engine through a valid/ready handshake.

When every check passes, the block raises `unlock`. The fetch and decrypt path may be enabled from that point. The first failing check instead drives the block into a locked state that only a reset can leave, and a 4-bit code names that check. Magic value, header version and the masks of permitted bits are elaboration-time parameters. The cryptographic engines themselves sit outside the block.

Top module: `image_gatekeeper`

## Requirements
- R1: After reset `unlock`, `locked`, `fail_code` and `tag_ready` are all 0.
- R2: The header is fetched by asserting `mem_rd_en` with `mem_addr` stepping 0, 1, ..., 31, each address exactly once and in ascending order. Read data is taken one cycle after its request, and no address of 32 or above is requested.
- R3: Word 0 differing from parameter MAGIC locks with code 1. Word 1 differing from parameter VERSION locks with code 2.
- R4: The policy word 3 having any bit set outside POLICY_MASK locks with code 3.
- R5: A region passes when start + count equals end without wrap, start >= 32 and end <= 1024 (end is one past the last word). Text uses words 4/5/6 as start/count/end and fails with code 4. Data uses words 28/29/30 and fails with code 5. Overlapping regions (text.start < data.end and data.start < text.end) fail with code 6.
- R6: Feature-flag word 2 with a bit outside FLAG_MASK, or data-flag word 31 with a bit outside DFLAG_MASK, locks with code 7.
- R7: A wrapped key (words 12 to 15) that is all zeros or all ones across its 128 bits locks with code 8.
- R8: When several header checks fail, the smallest code is reported, following the order magic, version, policy, text, data, overlap, flags, wrapped key.
- R9: Only after all header checks pass does `tag_ready` rise with `tag_sel`=0, asking for the key tag. A header failure means no tag is ever requested. An accepted `tag_value` is compared on all 128 bits against words 16 to 19, with `tag_value[32*i +: 32]` matched against word 16+i. A mismatch locks with code 9.
- R10: After the key tag matches, `tag_ready` stays high with `tag_sel`=1, and the value is compared with words 20 to 23 in the same packing. A mismatch locks with code 10. A match raises `unlock` with code 0.
- R11: The block waits for `tag_valid` without limit and never times out. `tag_valid` while `tag_ready` is low has no effect.
- R12: `unlock` and `locked` are never both high. Once either is set, it and `fail_code` hold until reset whatever the inputs do. `fail_code` is nonzero exactly when `locked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Image memory read request |
| mem_addr | output | 10 | Image word address |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |
| tag_ready | output | 1 | Block is waiting for a computed tag |
| tag_sel | output | 1 | 0 = key tag wanted, 1 = image tag wanted |
| tag_valid | input | 1 | MAC engine presents a tag |
| tag_value | input | 128 | Computed tag, word 16+i (or 20+i) in bits 32*i+31..32*i |
| unlock | output | 1 | All checks passed; execution may start |
| locked | output | 1 | A check failed; execution refused until reset |
| fail_code | output | 4 | First failing check, 0 when none |

## Verification
The hardest situations to reach are the ones where the MAC engine misbehaves around the handshake. One is a tag offered before any request, with a value that would fail the comparison. The other is a tag withheld for a long stretch while the block must sit quietly. The stimulus drives a junk `tag_valid` whenever `tag_ready` is low and delays the real answer by a programmable number of cycles. A further difficulty is proving that the first failure wins. Headers are built with several simultaneous faults and with bounds set exactly at words 32 and 1024, plus an address sum that wraps at 32 bits.

// File: rtl/gk_pkg.sv
package gk_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_CHECK,
      ST_KEYTAG,
      ST_IMGTAG,
      ST_OPEN,
      ST_SHUT
   } gk_state_e;

   localparam logic [3:0] FC_PASS    = 4'd0;
   localparam logic [3:0] FC_MAGIC   = 4'd1;
   localparam logic [3:0] FC_VERSION = 4'd2;
   localparam logic [3:0] FC_POLICY  = 4'd3;
   localparam logic [3:0] FC_TEXT    = 4'd4;
   localparam logic [3:0] FC_DATA    = 4'd5;
   localparam logic [3:0] FC_OVERLAP = 4'd6;
   localparam logic [3:0] FC_FLAGS   = 4'd7;
   localparam logic [3:0] FC_WRAPKEY = 4'd8;
   localparam logic [3:0] FC_KEYTAG  = 4'd9;
   localparam logic [3:0] FC_IMGTAG  = 4'd10;

   // header word positions that the checks decode
   localparam int W_MAGIC   = 0;
   localparam int W_VERSION = 1;
   localparam int W_FEAT    = 2;
   localparam int W_POLICY  = 3;
   localparam int W_TEXT    = 4;
   localparam int W_WKEY    = 12;
   localparam int W_KTAG    = 16;
   localparam int W_ITAG    = 20;
   localparam int W_DATA    = 28;
   localparam int W_DFLAG   = 31;

endpackage

// File: rtl/gk_hdr_store.sv
module gk_hdr_store #(
   parameter int WORD_W    = 32,
   parameter int HDR_WORDS = 32,
   parameter int ADDR_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [WORD_W-1:0] words_o [HDR_WORDS],
   output logic              loaded_o
);

   localparam int IDX_W = $clog2(HDR_WORDS);
   localparam int CNT_W = IDX_W + 1;
   localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(HDR_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_WORDS - 1);

   logic [CNT_W-1:0]  issue_q;
   logic              cap_pend_q;
   logic [IDX_W-1:0]  cap_idx_q;
   logic              loaded_q;
   logic [WORD_W-1:0] word_q [HDR_WORDS];

   assign mem_rd_en = run && (issue_q < CNT_END);
   assign mem_addr  = ADDR_W'(issue_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_q    <= '0;
         cap_pend_q <= 1'b0;
         cap_idx_q  <= '0;
      end else begin
         cap_pend_q <= mem_rd_en;
         cap_idx_q  <= issue_q[IDX_W-1:0];
         if (mem_rd_en) issue_q <= issue_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < HDR_WORDS; i++) word_q[i] <= '0;
         loaded_q <= 1'b0;
      end else if (cap_pend_q) begin
         word_q[cap_idx_q] <= mem_rdata;
         if (cap_idx_q == IDX_LAST) loaded_q <= 1'b1;
      end
   end

   assign words_o  = word_q;
   assign loaded_o = loaded_q;

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mem_rd_en) && mem_rd_en) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R2
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_addr < ADDR_W'(HDR_WORDS)));

   // R2
   load_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded_o) |-> $past(cap_pend_q));

endmodule

// File: rtl/gk_field_check.sv
module gk_field_check
   import gk_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int          HDR_WORDS   = 32,
   parameter int          IMG_WORDS   = 1024,
   parameter logic [31:0] MAGIC       = 32'hC0DE_5EA1,
   parameter logic [31:0] VERSION     = 32'h0000_0003,
   parameter logic [31:0] POLICY_MASK = 32'h0000_00FF,
   parameter logic [31:0] FLAG_MASK   = 32'h0000_FFFF,
   parameter logic [31:0] DFLAG_MASK  = 32'h0000_000F
) (
   input  logic [WORD_W-1:0] words [HDR_WORDS],
   output logic [3:0]        code_o
);

   localparam int SUM_W = WORD_W + 1;
   localparam logic [SUM_W-1:0] LO_BOUND = SUM_W'(HDR_WORDS);
   localparam logic [SUM_W-1:0] HI_BOUND = SUM_W'(IMG_WORDS);
   localparam int NREG = 2;

   logic [NREG-1:0]   region_ok;
   logic [WORD_W-1:0] r_start [NREG];
   logic [WORD_W-1:0] r_stop  [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_region
      localparam int BASE = (r == 0) ? W_TEXT : W_DATA;
      logic [SUM_W-1:0] s_ext, c_ext, e_ext, sum;
      assign s_ext = {1'b0, words[BASE]};
      assign c_ext = {1'b0, words[BASE+1]};
      assign e_ext = {1'b0, words[BASE+2]};
      assign sum   = s_ext + c_ext;
      assign region_ok[r] = (sum == e_ext) && (s_ext >= LO_BOUND) && (e_ext <= HI_BOUND);
      assign r_start[r] = words[BASE];
      assign r_stop[r]  = words[BASE+2];
   end

   logic overlap;
   assign overlap = (r_start[0] < r_stop[1]) && (r_start[1] < r_stop[0]);

   logic [4*WORD_W-1:0] wkey;
   for (genvar k = 0; k < 4; k++) begin : g_wkey
      assign wkey[k*WORD_W +: WORD_W] = words[W_WKEY+k];
   end

   logic magic_bad, version_bad, policy_bad, flags_bad, wkey_bad;
   assign magic_bad   = words[W_MAGIC] != MAGIC;
   assign version_bad = words[W_VERSION] != VERSION;
   assign policy_bad  = (words[W_POLICY] & ~POLICY_MASK) != '0;
   assign flags_bad   = ((words[W_FEAT] & ~FLAG_MASK) != '0) ||
                        ((words[W_DFLAG] & ~DFLAG_MASK) != '0);
   assign wkey_bad    = (wkey == '0) || (&wkey);

   always_comb begin
      if      (magic_bad)     code_o = FC_MAGIC;
      else if (version_bad)   code_o = FC_VERSION;
      else if (policy_bad)    code_o = FC_POLICY;
      else if (!region_ok[0]) code_o = FC_TEXT;
      else if (!region_ok[1]) code_o = FC_DATA;
      else if (overlap)       code_o = FC_OVERLAP;
      else if (flags_bad)     code_o = FC_FLAGS;
      else if (wkey_bad)      code_o = FC_WRAPKEY;
      else                    code_o = FC_PASS;
   end

endmodule

// File: rtl/gk_tag_cmp.sv
module gk_tag_cmp #(
   parameter int WORD_W    = 32,
   parameter int TAG_WORDS = 4
) (
   input  logic [TAG_WORDS*WORD_W-1:0] got,
   input  logic [TAG_WORDS*WORD_W-1:0] want,
   output logic                        match
);

   logic [TAG_WORDS-1:0] lane_eq;

   for (genvar i = 0; i < TAG_WORDS; i++) begin : g_lane
      assign lane_eq[i] = got[i*WORD_W +: WORD_W] == want[i*WORD_W +: WORD_W];
   end

   assign match = &lane_eq;

endmodule

// File: rtl/image_gatekeeper.sv
module image_gatekeeper
   import gk_pkg::*;
#(
   parameter int          WORD_W      = 32,
   parameter int          HDR_WORDS   = 32,
   parameter int          IMG_WORDS   = 1024,
   parameter int          TAG_WORDS   = 4,
   parameter logic [31:0] MAGIC       = 32'hC0DE_5EA1,
   parameter logic [31:0] VERSION     = 32'h0000_0003,
   parameter logic [31:0] POLICY_MASK = 32'h0000_00FF,
   parameter logic [31:0] FLAG_MASK   = 32'h0000_FFFF,
   parameter logic [31:0] DFLAG_MASK  = 32'h0000_000F,
   localparam int         ADDR_W      = $clog2(IMG_WORDS),
   localparam int         TAG_W       = TAG_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              tag_ready,
   output logic              tag_sel,
   input  logic              tag_valid,
   input  logic [TAG_W-1:0]  tag_value,
   output logic              unlock,
   output logic              locked,
   output logic [3:0]        fail_code
);

   if (WORD_W != 32) begin : g_bad_word
      $error("image_gatekeeper: header layout needs 32-bit words");
   end
   if (HDR_WORDS != 32) begin : g_bad_hdr
      $error("image_gatekeeper: header layout needs 32 words");
   end
   if (TAG_WORDS != 4) begin : g_bad_tag
      $error("image_gatekeeper: tags are four words");
   end
   if (IMG_WORDS <= HDR_WORDS || (1 << ADDR_W) != IMG_WORDS) begin : g_bad_img
      $error("image_gatekeeper: image size must be a power of two above the header");
   end

   gk_state_e         state_q;
   logic [3:0]        fail_q;
   logic [WORD_W-1:0] hdr_w [HDR_WORDS];
   logic              hdr_loaded;
   logic [3:0]        field_code;
   logic [TAG_W-1:0]  exp_key, exp_img, exp_sel;
   logic              tag_match;

   gk_hdr_store #(
      .WORD_W   (WORD_W),
      .HDR_WORDS(HDR_WORDS),
      .ADDR_W   (ADDR_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state_q == ST_READ),
      .mem_rd_en(mem_rd_en),
      .mem_addr (mem_addr),
      .mem_rdata(mem_rdata),
      .words_o  (hdr_w),
      .loaded_o (hdr_loaded)
   );

   gk_field_check #(
      .WORD_W     (WORD_W),
      .HDR_WORDS  (HDR_WORDS),
      .IMG_WORDS  (IMG_WORDS),
      .MAGIC      (MAGIC),
      .VERSION    (VERSION),
      .POLICY_MASK(POLICY_MASK),
      .FLAG_MASK  (FLAG_MASK),
      .DFLAG_MASK (DFLAG_MASK)
   ) u_fields (
      .words (hdr_w),
      .code_o(field_code)
   );

   for (genvar i = 0; i < TAG_WORDS; i++) begin : g_expect
      assign exp_key[i*WORD_W +: WORD_W] = hdr_w[W_KTAG+i];
      assign exp_img[i*WORD_W +: WORD_W] = hdr_w[W_ITAG+i];
   end

   assign exp_sel = (state_q == ST_IMGTAG) ? exp_img : exp_key;

   gk_tag_cmp #(
      .WORD_W   (WORD_W),
      .TAG_WORDS(TAG_WORDS)
   ) u_tag (
      .got  (tag_value),
      .want (exp_sel),
      .match(tag_match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_READ;
         fail_q  <= FC_PASS;
      end else begin
         case (state_q)
            ST_READ: if (hdr_loaded) state_q <= ST_CHECK;
            ST_CHECK: begin
               if (field_code != FC_PASS) begin
                  state_q <= ST_SHUT;
                  fail_q  <= field_code;
               end else begin
                  state_q <= ST_KEYTAG;
               end
            end
            ST_KEYTAG: begin
               if (tag_valid) begin
                  if (tag_match) begin
                     state_q <= ST_IMGTAG;
                  end else begin
                     state_q <= ST_SHUT;
                     fail_q  <= FC_KEYTAG;
                  end
               end
            end
            ST_IMGTAG: begin
               if (tag_valid) begin
                  if (tag_match) begin
                     state_q <= ST_OPEN;
                  end else begin
                     state_q <= ST_SHUT;
                     fail_q  <= FC_IMGTAG;
                  end
               end
            end
            ST_OPEN: state_q <= ST_OPEN;
            ST_SHUT: state_q <= ST_SHUT;
            default: begin
               state_q <= ST_SHUT;
               fail_q  <= FC_MAGIC;
            end
         endcase
      end
   end

   assign tag_ready = (state_q == ST_KEYTAG) || (state_q == ST_IMGTAG);
   assign tag_sel   = (state_q == ST_IMGTAG);
   assign unlock    = (state_q == ST_OPEN);
   assign locked    = (state_q == ST_SHUT);
   assign fail_code = fail_q;

   // R12
   excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlock && locked));

   // R12
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (locked && $stable(fail_code)));

   // R12
   open_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock |=> (unlock && fail_code == FC_PASS));

   // R12
   code_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_code != FC_PASS) |-> locked);

   // R9
   tag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_ready |-> (hdr_loaded && field_code == FC_PASS));

   // R11
   tag_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_ready && !tag_valid) |=> (tag_ready && $stable(tag_sel)));

   // R10
   open_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlock) |-> $past(tag_valid && tag_ready && tag_sel));

endmodule

// File: tb/sim_image_gatekeeper.sv
module sim_image_gatekeeper;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] P_MAGIC    = 32'hC0DE_5EA1;
   localparam logic [31:0] P_VERSION  = 32'h0000_0003;
   localparam logic [31:0] P_POLMASK  = 32'h0000_00FF;
   localparam logic [31:0] P_FLAGMASK = 32'h0000_FFFF;
   localparam logic [31:0] P_DFLMASK  = 32'h0000_000F;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mem_rd_en;
   logic [9:0]   mem_addr;
   logic [31:0]  mem_rdata = '0;
   logic         tag_ready, tag_sel;
   logic         tag_valid = 1'b0;
   logic [127:0] tag_value = '0;
   logic         unlock, locked;
   logic [3:0]   fail_code;

   image_gatekeeper #(
      .MAGIC      (P_MAGIC),
      .VERSION    (P_VERSION),
      .POLICY_MASK(P_POLMASK),
      .FLAG_MASK  (P_FLAGMASK),
      .DFLAG_MASK (P_DFLMASK)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tag_ready(tag_ready), .tag_sel(tag_sel), .tag_valid(tag_valid), .tag_value(tag_value),
      .unlock(unlock), .locked(locked), .fail_code(fail_code)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] hdr [32];
   int          addr_q [$];

   // responder configuration
   int rsp_delay = 0;
   bit rsp_bad_key = 0, rsp_bad_img = 0, rsp_junk = 0;
   int wait_cnt = 0;
   bit last_sel = 0;

   // monitor state
   bit mon_on = 0, tag_seen = 0, term_seen = 0, term_open = 0;
   int term_code = 0;
   int exp_code = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // synchronous image memory, one cycle read latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= (mem_addr < 10'd32) ? hdr[mem_addr[4:0]] : 32'hBAD0_BAD0;
      if (rst_n && mem_rd_en) addr_q.push_back(int'(mem_addr));
   end

   // MAC engine stand-in
   always @(negedge clk) begin
      if (tag_ready) begin
         if (tag_sel != last_sel) wait_cnt = 0;
         last_sel = tag_sel;
         if (wait_cnt < rsp_delay) begin
            wait_cnt++;
            tag_valid <= 1'b0;
            tag_value <= 128'h0;
         end else begin
            tag_valid <= 1'b1;
            if (!tag_sel)
               tag_value <= {hdr[19], hdr[18], hdr[17], hdr[16]} ^ {127'd0, rsp_bad_key};
            else
               tag_value <= {hdr[23], hdr[22], hdr[21], hdr[20]} ^ {127'd0, rsp_bad_img};
         end
      end else begin
         wait_cnt = 0;
         last_sel = 0;
         tag_valid <= rsp_junk;
         tag_value <= 128'h0123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
      end
   end

   // per-clock comparison against the behavioural expectation
   always @(negedge clk) begin
      if (mon_on) begin
         chk(!(unlock && locked), "R12 exclusive", int'(unlock), 0);
         if (tag_ready) begin
            tag_seen = 1;
            chk(exp_code == 0 || exp_code > 8, "R9 tag request after header fault",
                exp_code, 0);
         end
         if (term_seen) begin
            chk(unlock == term_open && locked == !term_open && int'(fail_code) == term_code,
                "R12 sticky", int'(fail_code), term_code);
         end else if (unlock || locked) begin
            term_seen = 1;
            term_open = unlock;
            term_code = int'(fail_code);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // reference model from the requirements
   function automatic int model_code(input bit bk, input bit bi);
      longint ts, tc, te, ds, dc, de;
      bit t_ok, d_ok;
      ts = hdr[4];  tc = hdr[5];  te = hdr[6];
      ds = hdr[28]; dc = hdr[29]; de = hdr[30];
      t_ok = (ts + tc == te) && ts >= 32 && te <= 1024;
      d_ok = (ds + dc == de) && ds >= 32 && de <= 1024;
      if (hdr[0] != P_MAGIC) return 1;
      if (hdr[1] != P_VERSION) return 2;
      if ((hdr[3] & ~P_POLMASK) != 0) return 3;
      if (!t_ok) return 4;
      if (!d_ok) return 5;
      if (ts < de && ds < te) return 6;
      if ((hdr[2] & ~P_FLAGMASK) != 0 || (hdr[31] & ~P_DFLMASK) != 0) return 7;
      if ((hdr[12] | hdr[13] | hdr[14] | hdr[15]) == 0) return 8;
      if ((hdr[12] & hdr[13] & hdr[14] & hdr[15]) == 32'hFFFF_FFFF) return 8;
      if (bk) return 9;
      if (bi) return 10;
      return 0;
   endfunction

   task automatic make_good();
      for (int i = 0; i < 32; i++) hdr[i] = 32'h1000_0000 + i * 32'h0101_0101;
      hdr[0] = P_MAGIC;   hdr[1] = P_VERSION;
      hdr[2] = 32'h0000_00A5; hdr[3] = 32'h0000_0011;
      hdr[4] = 32;  hdr[5] = 100; hdr[6] = 132;
      hdr[28] = 200; hdr[29] = 50; hdr[30] = 250; hdr[31] = 32'h3;
   endtask

   task automatic run_case(input string req, input int hand, input int delay,
                           input bit bk, input bit bi, input bit junk);
      rst_n = 1'b0;
      mon_on = 0;
      rsp_delay = delay; rsp_bad_key = bk; rsp_bad_img = bi; rsp_junk = junk;
      repeat (3) @(posedge clk);
      addr_q.delete();
      tag_seen = 0; term_seen = 0;
      exp_code = model_code(bk, bi);
      chk(exp_code == hand, {req, " model"}, exp_code, hand);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(!unlock && !locked && fail_code == 0 && !tag_ready, "R1 reset state",
          int'(fail_code), 0);
      mon_on = 1;
      if (delay > 0) begin
         for (int n = 0; n < 200 && !tag_ready; n++) @(negedge clk);
         repeat (delay / 2) @(negedge clk);
         // R11 still waiting
         chk(tag_ready && !unlock && !locked, "R11 wait on handshake", int'(tag_ready), 1);
      end
      for (int n = 0; n < 4000 && !(unlock || locked); n++) @(negedge clk);
      chk(int'(fail_code) == exp_code, req, int'(fail_code), exp_code);
      chk(locked == (exp_code != 0) && unlock == (exp_code == 0), {req, " outputs"},
          int'(locked), int'(exp_code != 0));
      // R2 read order
      chk(addr_q.size() == 32, "R2 read count", addr_q.size(), 32);
      for (int i = 0; i < addr_q.size(); i++)
         if (addr_q[i] != i) chk(0, "R2 read order", addr_q[i], i);
      if (exp_code >= 1 && exp_code <= 8)
         chk(!tag_seen, "R9 no tag request", int'(tag_seen), 0);
      // R12 nothing clears the outcome
      rsp_junk = 1; rsp_bad_key = 0; rsp_bad_img = 0;
      repeat (40) @(negedge clk);
      chk(int'(fail_code) == exp_code && locked == (exp_code != 0), "R12 hold",
          int'(fail_code), exp_code);
      mon_on = 0;
   endtask

   initial begin
      make_good();
      run_case("R10 good image", 0, 0, 0, 0, 0);
      make_good(); hdr[0] = 32'hC0DE_5EA0;
      run_case("R3 magic", 1, 0, 0, 0, 0);
      make_good(); hdr[1] = 32'h4;
      run_case("R3 version", 2, 0, 0, 0, 0);
      make_good(); hdr[3] = 32'h0000_0100;
      run_case("R4 policy", 3, 0, 0, 0, 0);
      make_good(); hdr[6] = 133;
      run_case("R5 text sum", 4, 0, 0, 0, 0);
      make_good(); hdr[4] = 31; hdr[6] = 131;
      run_case("R5 text below header", 4, 0, 0, 0, 0);
      make_good(); hdr[4] = 32'hFFFF_FFF0; hdr[5] = 32'h20; hdr[6] = 32'h10;
      run_case("R5 text wrap", 4, 0, 0, 0, 0);
      make_good(); hdr[28] = 975; hdr[29] = 50; hdr[30] = 1025;
      run_case("R5 data past end", 5, 0, 0, 0, 0);
      make_good(); hdr[28] = 120; hdr[29] = 50; hdr[30] = 170;
      run_case("R5 overlap", 6, 0, 0, 0, 0);
      make_good(); hdr[4] = 32; hdr[5] = 0; hdr[6] = 32; hdr[28] = 32; hdr[29] = 992; hdr[30] = 1024;
      run_case("R5 edges pass", 0, 0, 0, 0, 0);
      make_good(); hdr[28] = 132; hdr[29] = 10; hdr[30] = 142;
      run_case("R5 adjacent pass", 0, 0, 0, 0, 0);
      make_good(); hdr[2] = 32'h0001_0000;
      run_case("R6 feature flags", 7, 0, 0, 0, 0);
      make_good(); hdr[31] = 32'h10;
      run_case("R6 data flags", 7, 0, 0, 0, 0);
      make_good(); hdr[12] = 0; hdr[13] = 0; hdr[14] = 0; hdr[15] = 0;
      run_case("R7 key zeros", 8, 0, 0, 0, 0);
      make_good(); hdr[12] = '1; hdr[13] = '1; hdr[14] = '1; hdr[15] = '1;
      run_case("R7 key ones", 8, 0, 0, 0, 0);
      make_good(); hdr[1] = 32'h9; hdr[28] = 120; hdr[29] = 50; hdr[30] = 170; hdr[2] = '1;
      run_case("R8 first fault wins", 2, 0, 0, 0, 0);
      make_good(); hdr[3] = 32'h8000_0000; hdr[12] = 0; hdr[13] = 0; hdr[14] = 0; hdr[15] = 0;
      run_case("R8 policy before key", 3, 0, 0, 0, 0);
      make_good();
      run_case("R9 key tag mismatch", 9, 0, 1, 0, 0);
      make_good();
      run_case("R10 image tag mismatch", 10, 0, 0, 1, 0);
      make_good();
      run_case("R11 slow engine with junk", 0, 120, 0, 0, 1);
      make_good();
      run_case("R11 slow engine bad image", 10, 60, 0, 1, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule